// File: doc/BRIEF.md
# Configurable GPIO Pin Controller with Edge Detection

This block controls one general-purpose I/O pin. Software reaches it through a small register port with two byte-wide registers. The drive register sets the pin direction, the driver style (push-pull or open-drain), the pull resistor and the output value. The sense register returns the synchronized pin level and selects which edges of that level raise an event.

The controller drives the pad-control signals directly: output enable, output data, an open-drain flag, a pull enable and a two-bit pull select. It samples the pad input through a two-stage synchronizer. Level readback and edge detection both use the synchronized value. A matching edge produces a pulse for an external interrupt aggregator.

Register access has no wait states. A write lands at the clock edge where `wr_en` is high. `rd_data` always shows the register chosen by `reg_sel`.

Top module: `gpio_pin_ctl`

## Requirements
- R1: After reset the following hold: the drive register reads 0x00; the sense register reads 0x00 while `pad_in` is low; `pad_oe`, `pad_pull_en` and `edge_evt` are 0.
- R2: With `reg_sel`=0, a write stores `wr_data[5:0]` in the drive register. Reads return those bits, and bits 7:6 always read 0.
- R3: When drive bit 5 is 0 (input direction), `pad_oe` is 0 whatever the other drive bits hold.
- R4: When drive bit 5 is 1 and bit 4 is 1 (push-pull), `pad_oe` is 1, `pad_out` equals drive bit 0, and `pad_od` is 0.
- R5: When drive bit 5 is 1 and bit 4 is 0 (open-drain), `pad_od` is 1 and `pad_out` is 0. `pad_oe` is 1 when drive bit 0 is 0 and 0 when drive bit 0 is 1.
- R6: `pad_pull_en` equals drive bit 3 and `pad_pull_sel` equals drive bits 2:1 in either direction. The codes are 00 for 2k down, 01 for 2k up, 10 for 50k down and 11 for 50k up.
- R7: Sense bit 0 shows `pad_in` after two clock edges. Writes to that bit have no effect.
- R8: With `reg_sel`=1, a write stores `wr_data[2:1]` as the edge mode. The mode reads back in sense bits 2:1, and bits 7:3 always read 0.
- R9: `edge_evt` is high for the single cycle in which sense bit 0 first shows a new level, but only if that level change matches the mode. Mode 01 means falling, 10 means rising and 11 means both. Mode 00 never produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects drive register, 1 selects sense register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| pad_in | input | 1 | Pad input level |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output data |
| pad_od | output | 1 | Open-drain driver selected |
| pad_pull_en | output | 1 | Pull resistor enable |
| pad_pull_sel | output | 2 | Pull strength and direction |
| edge_evt | output | 1 | Single-cycle edge event |

## Verification
The bench builds the block with its default two-stage synchronizer. This puts the exact two-edge readback latency and the cycle of the event pulse within direct reach.

All 64 writable drive-register values are swept, and the pad outputs are checked against values derived arithmetically from the bits. All four edge modes are each crossed with a rising and a falling pad transition. The event is checked in the cycle before, during and after its expected slot. Writes to the read-only level bit and to the unused high bits are checked for having no effect.

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          pad_in,
  output logic          pad_oe,
  output logic          pad_out,
  output logic          pad_od,
  output logic          pad_pull_en,
  output logic [1:0]    pad_pull_sel,
  output logic          edge_evt
);
  localparam int CW = 6;

  logic [CW-1:0]          drv;
  logic [1:0]             mode;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_prev;
  logic                   lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv  <= '0;
      mode <= 2'b00;
    end else if (wr_en) begin
      if (reg_sel) mode <= wr_data[2:1];
      else         drv  <= wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      lvl_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], pad_in};
      lvl_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  wire dir_out   = drv[5];
  wire push_pull = drv[4];

  assign pad_oe       = dir_out & (push_pull | ~drv[0]);
  assign pad_out      = push_pull & drv[0];
  assign pad_od       = ~push_pull;
  assign pad_pull_en  = drv[3];
  assign pad_pull_sel = drv[2:1];

  assign edge_evt = (mode[1] & lvl & ~lvl_prev) | (mode[0] & ~lvl & lvl_prev);

  assign rd_data = reg_sel ? DW'({mode, lvl}) : DW'(drv);

  // R3
  in_dir_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[5] && !reg_sel |-> !pad_oe);

  // R5
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_od && pad_oe |-> !pad_out);

  // R9
  no_evt_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> !edge_evt);

  // R9
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && mode == 2'b10 |-> lvl);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && mode != 2'b11 |=> !edge_evt || mode != $past(mode));
endmodule

// File: tb/gpio_pin_ctl_bench.sv
module gpio_pin_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, reg_sel = 0, wr_en = 0, pad_in = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic pad_oe, pad_out, pad_od, pad_pull_en, edge_evt;
  logic [1:0] pad_pull_sel;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pin_ctl u_gpio_pin_ctl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
    .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel),
    .edge_evt(edge_evt));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic edge_case(input logic [1:0] m, input logic to);
    logic exp;
    wr(1'b1, {5'b0, m, 1'b0});
    reg_sel = 1;
    pad_in = ~to;
    repeat (4) @(negedge clk);
    pad_in = to;
    exp = to ? m[1] : m[0];
    @(negedge clk);
    chk("R7 level before latency", {7'b0, rd_data[0]}, {7'b0, ~to});
    chk("R9 no early event", {7'b0, edge_evt}, 8'h00);
    @(negedge clk);
    chk("R7 level after two edges", {7'b0, rd_data[0]}, {7'b0, to});
    chk("R9 event slot", {7'b0, edge_evt}, {7'b0, exp});
    @(negedge clk);
    chk("R9 event single cycle", {7'b0, edge_evt}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe", {7'b0, pad_oe}, 8'h00);
    chk("R1 pull_en", {7'b0, pad_pull_en}, 8'h00);
    chk("R1 evt", {7'b0, edge_evt}, 8'h00);
    chk("R1 drive reg", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 drive reg after release", rd_data, 8'h00);
    reg_sel = 1;
    #1;
    chk("R1 sense reg", rd_data, 8'h00);

    for (int v = 0; v < 256; v += 1) begin
      logic [7:0] d;
      logic exp_oe, exp_out;
      d = v[7:0];
      wr(1'b0, d);
      reg_sel = 0;
      #1;
      chk("R2 readback", rd_data, {2'b00, d[5:0]});
      exp_oe  = d[5] & (d[4] | ~d[0]);
      exp_out = d[4] & d[0];
      if (!d[5]) chk("R3 input no drive", {7'b0, pad_oe}, 8'h00);
      else if (d[4]) begin
        chk("R4 push-pull oe", {7'b0, pad_oe}, 8'h01);
        chk("R4 push-pull out", {7'b0, pad_out}, {7'b0, d[0]});
        chk("R4 push-pull od", {7'b0, pad_od}, 8'h00);
      end else begin
        chk("R5 open-drain oe", {7'b0, pad_oe}, {7'b0, exp_oe});
        chk("R5 open-drain out", {7'b0, pad_out}, {7'b0, exp_out});
        chk("R5 open-drain od", {7'b0, pad_od}, 8'h01);
      end
      chk("R6 pull enable", {7'b0, pad_pull_en}, {7'b0, d[3]});
      chk("R6 pull select", {6'b0, pad_pull_sel}, {6'b0, d[2:1]});
    end

    wr(1'b0, 8'h00);
    for (int v = 0; v < 256; v += 1) begin
      logic [7:0] d;
      d = v[7:0];
      wr(1'b1, d);
      reg_sel = 1;
      #1;
      chk("R8 sense readback", rd_data, {5'b0, d[2:1], 1'b0});
      chk("R7 level bit ignores write", {7'b0, rd_data[0]}, 8'h00);
    end

    for (int m = 0; m < 4; m += 1) begin
      edge_case(m[1:0], 1'b1);
      edge_case(m[1:0], 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule